// File: doc/BRIEF.md
# Configuration Bitstream Stream Controller

This block sits between a host bus and a chain of programmable-logic targets that are being configured. The host, or a DMA engine acting for it, pushes 32-bit bitstream words into an internal word FIFO through a write-only data port. The block drains the FIFO toward the targets over a simple ready/valid style link and counts every byte it sends. It decides that configuration has finished once the count it has sent equals a total that the host loaded beforehand and the targets report that they are done.

Software sees a small register window: control (enable, target reset pulse, DMA pacing), status (done flag plus an error field), FIFO capacity, FIFO occupancy, total byte count and sent byte count. A single interrupt line reports completion or failure. Writing the control register with enable cleared acknowledges the interrupt and empties the FIFO. In DMA mode, a request output asks for another burst of half the FIFO whenever that much space is free.

Top module: `cfg_stream_ctrl`

## Requirements
- R1: After reset, reads return 0 at control (0x40), status (0x44), occupancy (0x4C), total (0x50) and sent count (0x54); irq, dma_req, tgt_valid and tgt_reset are low. Read data is registered and valid the cycle after bus_rd.
- R2: Offset 0x48 reads the FIFO capacity in bytes (4 x FIFO_DEPTH), and 0x4C reads the current occupancy in bytes (4 x words held).
- R3: A write to offset 0x3000 while enable (control bit 0) is set and the FIFO is not full stores the word. Stored words leave on tgt_data in write order. A word leaves the FIFO in each cycle where tgt_ready is high, enable is set, no target error is latched and the FIFO is not empty. tgt_valid is high with that word in the following cycle.
- R4: A write to 0x3000 while enable is clear or the FIFO is full is dropped and sets status bit 1 (overflow).
- R5: Offset 0x50 holds the host-written total byte count. Offset 0x54 rises by 4 for each word sent. Setting enable from 0 to 1 clears the sent count, the done flag and all error bits.
- R6: Status bit 18 (done) sets while enabled when the sent count equals the total and tgt_done is high. tgt_done alone with a smaller count does not set it.
- R7: tgt_err while enabled latches status bit 2, and no further words are sent until enable is set again.
- R8: irq rises while enabled when done or any error bit is set. It clears on any control write with bit 0 clear, and that write also empties the FIFO.
- R9: dma_req is high, one cycle after the condition, while control bits 0 and 2 are set and at least FIFO_DEPTH/2 words are free.
- R10: A control write with bit 1 set drives tgt_reset high for one cycle after the write and clears the done flag.
- R11: A FIFO write and a word sent in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | BUS_AW | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| dma_req | output | 1 | Burst request toward the DMA engine |
| irq | output | 1 | Completion or failure interrupt |
| tgt_ready | input | 1 | Target will take a word next cycle |
| tgt_done | input | 1 | Targets report configuration done |
| tgt_err | input | 1 | Targets report a configuration error |
| tgt_valid | output | 1 | tgt_data carries a bitstream word |
| tgt_data | output | 32 | Bitstream word toward the targets |
| tgt_reset | output | 1 | Single-cycle deconfigure pulse |

## Verification
A host write into the data port and a word leaving toward the targets can land on the same clock edge. That is the case where the occupancy counter must neither gain nor lose a word. The bench first leaves one word in the FIFO with the target stalled. It then raises tgt_ready on the same cycle as a second data-port write. The edge must both send the old word and store the new one, so the bench checks that the occupancy still reads 4 bytes and that the word sent is the older one.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  // byte offsets decoded by the host software
  localparam int OFS_CTRL  = 'h0040;
  localparam int OFS_STAT  = 'h0044;
  localparam int OFS_SIZE  = 'h0048;
  localparam int OFS_OCC   = 'h004C;
  localparam int OFS_TOTAL = 'h0050;
  localparam int OFS_SENT  = 'h0054;
  localparam int OFS_PORT  = 'h3000;
  // control bits
  localparam int CTL_EN  = 0;
  localparam int CTL_RST = 1;
  localparam int CTL_DMA = 2;
  // status bits
  localparam int ST_OVF  = 1;
  localparam int ST_TERR = 2;
  localparam int ST_DONE = 18;

  typedef struct packed {
    logic dma;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/cfg_fifo.sv
module cfg_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int OW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [OW-1:0] occ,
  output logic          full,
  output logic          empty
);
  // DEPTH is a power of two; pointers wrap on their own
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign full  = (occ == OW'(DEPTH));
  assign empty = (occ == '0);

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
    if (pop)  rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_drain.sv
module cfg_drain #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             halt,
  input  logic             fifo_empty,
  input  logic             tgt_ready,
  input  logic             tgt_done,
  input  logic [CNT_W-1:0] total,
  output logic             pop,
  output logic             tgt_valid,
  output logic [CNT_W-1:0] sent,
  output logic             done
);
  assign pop = en && !halt && !fifo_empty && tgt_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_valid <= 1'b0;
      sent      <= '0;
      done      <= 1'b0;
    end else begin
      tgt_valid <= pop;
      if (clr)
        sent <= '0;
      else if (pop)
        sent <= sent + CNT_W'(4);
      if (clr)
        done <= 1'b0;
      else if (en && tgt_done && (sent == total))
        done <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_stream_ctrl.sv
module cfg_stream_ctrl
  import cfg_stream_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int BUS_AW     = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              dma_req,
  output logic              irq,
  input  logic              tgt_ready,
  input  logic              tgt_done,
  input  logic              tgt_err,
  output logic              tgt_valid,
  output logic [31:0]       tgt_data,
  output logic              tgt_reset
);
  localparam int OW   = $clog2(FIFO_DEPTH) + 1;
  localparam int HALF = FIFO_DEPTH / 2;

  ctrl_t       ctrl_q;
  logic        en_q;
  logic [31:0] total_q;
  logic        ovf_q, terr_q;
  logic [OW-1:0] occ;
  logic        full, empty, pop, done;
  logic [31:0] sent;

  // bus decode
  logic wr_ctl, wr_port, start, stop, pulse, push, drop;
  assign en_q    = ctrl_q.en;
  assign wr_ctl  = bus_wr && (bus_addr == BUS_AW'(OFS_CTRL));
  assign wr_port = bus_wr && (bus_addr == BUS_AW'(OFS_PORT));
  assign start   = wr_ctl && bus_wdata[CTL_EN] && !en_q;
  assign stop    = wr_ctl && !bus_wdata[CTL_EN];
  assign pulse   = wr_ctl && bus_wdata[CTL_RST];
  assign push    = wr_port && en_q && !full;
  assign drop    = wr_port && !push;

  cfg_fifo #(.DW(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(stop), .push(push), .wdata(bus_wdata),
    .pop(pop), .rdata(tgt_data), .occ(occ), .full(full), .empty(empty)
  );

  cfg_drain #(.CNT_W(32)) u_drain (
    .clk(clk), .rst(rst), .clr(start || pulse), .en(en_q), .halt(terr_q),
    .fifo_empty(empty), .tgt_ready(tgt_ready), .tgt_done(tgt_done),
    .total(total_q), .pop(pop), .tgt_valid(tgt_valid), .sent(sent),
    .done(done)
  );

  // control, errors, interrupt, DMA pacing
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      total_q   <= '0;
      ovf_q     <= 1'b0;
      terr_q    <= 1'b0;
      irq       <= 1'b0;
      tgt_reset <= 1'b0;
      dma_req   <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ctrl_q.en  <= bus_wdata[CTL_EN];
        ctrl_q.dma <= bus_wdata[CTL_DMA];
      end
      if (bus_wr && (bus_addr == BUS_AW'(OFS_TOTAL)))
        total_q <= bus_wdata;
      if (start)      ovf_q <= 1'b0;
      else if (drop)  ovf_q <= 1'b1;
      if (start)                  terr_q <= 1'b0;
      else if (en_q && tgt_err)   terr_q <= 1'b1;
      if (stop)
        irq <= 1'b0;
      else if (en_q && (done || ovf_q || terr_q))
        irq <= 1'b1;
      tgt_reset <= pulse;
      dma_req   <= en_q && ctrl_q.dma && (occ <= OW'(HALF));
    end
  end

  // registered read port
  logic [31:0] status;
  always_comb begin
    status          = '0;
    status[ST_OVF]  = ovf_q;
    status[ST_TERR] = terr_q;
    status[ST_DONE] = done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        BUS_AW'(OFS_CTRL):  bus_rdata <= {29'd0, ctrl_q.dma, 1'b0, ctrl_q.en};
        BUS_AW'(OFS_STAT):  bus_rdata <= status;
        BUS_AW'(OFS_SIZE):  bus_rdata <= 32'(FIFO_DEPTH * 4);
        BUS_AW'(OFS_OCC):   bus_rdata <= 32'(occ) << 2;
        BUS_AW'(OFS_TOTAL): bus_rdata <= total_q;
        BUS_AW'(OFS_SENT):  bus_rdata <= sent;
        default:            bus_rdata <= '0;
      endcase
    end
  end
endmodule

module cfg_stream_ctrl_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int BUS_AW     = 14,
  localparam int OW        = $clog2(FIFO_DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              tgt_valid,
  input logic              tgt_reset,
  input logic              irq,
  input logic              dma_req,
  input logic              en,
  input logic              terr,
  input logic [OW-1:0]     occ
);
  logic ctl_wr;
  assign ctl_wr = bus_wr && (bus_addr == BUS_AW'(cfg_stream_pkg::OFS_CTRL));

  // R8
  irq_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !bus_wdata[0]) |=> !irq);

  // R3
  idle_no_send_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tgt_valid);

  // R9
  dma_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !dma_req);

  // R7
  halt_on_err_chk: assert property (@(posedge clk) disable iff (rst)
    (terr && $past(terr)) |-> !tgt_valid);

  // R10
  rst_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_reset |-> $past(ctl_wr && bus_wdata[1]));

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= OW'(FIFO_DEPTH));
endmodule

bind cfg_stream_ctrl cfg_stream_ctrl_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .BUS_AW(BUS_AW)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tgt_valid(tgt_valid), .tgt_reset(tgt_reset),
  .irq(irq), .dma_req(dma_req), .en(en_q), .terr(terr_q), .occ(occ)
);

// File: tb/test_cfg_stream_ctrl.sv
module test_cfg_stream_ctrl;
  localparam int DEPTH = 16;
  localparam int AW    = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic dma_req, irq, tgt_valid, tgt_reset;
  logic [31:0] tgt_data;
  logic tgt_ready = 1'b0, tgt_done = 1'b0, tgt_err = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int ncap = 0;
  int rst_cycles = 0;
  logic [31:0] cap [64];

  always #2.5 clk = ~clk;

  cfg_stream_ctrl #(.FIFO_DEPTH(DEPTH), .BUS_AW(AW)) i_cfg_stream_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_req(dma_req), .irq(irq), .tgt_ready(tgt_ready),
    .tgt_done(tgt_done), .tgt_err(tgt_err), .tgt_valid(tgt_valid),
    .tgt_data(tgt_data), .tgt_reset(tgt_reset)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (tgt_valid && ncap < 64) begin
      cap[ncap] <= tgt_data;
      ncap <= ncap + 1;
    end
    if (tgt_reset) rst_cycles <= rst_cycles + 1;
  end

  // reset-state table: {offset, expected value}
  localparam logic [45:0] RST_TAB [6] = '{
    {14'h0040, 32'h0}, {14'h0044, 32'h0}, {14'h0048, 32'(DEPTH * 4)},
    {14'h004C, 32'h0}, {14'h0050, 32'h0}, {14'h0054, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int base;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 / R2: reset values through the table
    for (int i = 0; i < 6; i++) begin
      rd(RST_TAB[i][45:32], v);
      chk("R1/R2 reset register", v, RST_TAB[i][31:0]);
    end
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 dma_req after reset", {31'd0, dma_req}, 32'd0);

    // R4: write while disabled is dropped and flags overflow
    wr(14'h3000, 32'hDEAD0000);
    rd(14'h0044, v); chk("R4 overflow bit when disabled", v, 32'h2);
    rd(14'h004C, v); chk("R4 dropped word not stored", v, 32'h0);

    // R5 / R6: load total, enable, fill with target stalled
    tgt_done = 1'b1;
    wr(14'h0050, 32'd16);
    rd(14'h0050, v); chk("R5 total readback", v, 32'd16);
    wr(14'h0040, 32'h1);
    rd(14'h0044, v); chk("R5 enable clears errors", v, 32'h0);
    for (int i = 0; i < 4; i++) wr(14'h3000, 32'hA5A50000 + 32'(i));
    rd(14'h004C, v); chk("R2 occupancy bytes", v, 32'd16);
    idle(3);
    chk("R6 done input alone no irq", {31'd0, irq}, 32'd0);
    chk("R9 no dma_req without DMA bit", {31'd0, dma_req}, 32'd0);

    // R3: drain in order
    tgt_ready = 1'b1;
    idle(12);
    tgt_ready = 1'b0;
    chk("R3 words sent", 32'(ncap), 32'd4);
    for (int i = 0; i < 4; i++)
      chk("R3 word order", cap[i], 32'hA5A50000 + 32'(i));
    rd(14'h0054, v); chk("R5 sent count", v, 32'd16);
    rd(14'h004C, v); chk("R2 occupancy after drain", v, 32'd0);
    chk("R6 irq on completion", {31'd0, irq}, 32'd1);
    rd(14'h0044, v); chk("R6 done bit", v, 32'h40000);
    tgt_done = 1'b0;

    // R8: acknowledge
    wr(14'h0040, 32'h0);
    idle(1);
    chk("R8 irq cleared by disable", {31'd0, irq}, 32'd0);

    // R10: reset pulse clears done
    wr(14'h0040, 32'h3);
    wr(14'h0040, 32'h0);
    idle(2);
    chk("R10 reset pulse length", 32'(rst_cycles), 32'd1);
    rd(14'h0044, v); chk("R10 done cleared by pulse", v, 32'h0);

    // R9: DMA pacing
    wr(14'h0040, 32'h5);
    idle(2);
    chk("R9 dma_req with room", {31'd0, dma_req}, 32'd1);
    for (int i = 0; i < DEPTH / 2 + 1; i++) wr(14'h3000, 32'(i));
    idle(2);
    chk("R9 dma_req drops below half free", {31'd0, dma_req}, 32'd0);
    rd(14'h004C, v); chk("R2 occupancy in DMA mode", v, 32'((DEPTH / 2 + 1) * 4));

    // R4: overflow when full
    for (int i = 0; i < DEPTH / 2 - 1; i++) wr(14'h3000, 32'(i));
    wr(14'h3000, 32'hFFFF_FFFF);
    rd(14'h004C, v); chk("R4 full occupancy", v, 32'(DEPTH * 4));
    rd(14'h0044, v); chk("R4 overflow bit when full", v, 32'h2);
    idle(2);
    chk("R8 irq on overflow", {31'd0, irq}, 32'd1);

    // R8: disable flushes
    wr(14'h0040, 32'h0);
    idle(2);
    chk("R8 irq cleared", {31'd0, irq}, 32'd0);
    rd(14'h004C, v); chk("R8 disable flushes FIFO", v, 32'd0);

    // R7: target error halts draining
    wr(14'h0040, 32'h1);
    wr(14'h3000, 32'h11111111);
    wr(14'h3000, 32'h22222222);
    @(negedge clk); tgt_err = 1'b1;
    @(negedge clk); tgt_err = 1'b0;
    base = ncap;
    tgt_ready = 1'b1;
    idle(6);
    tgt_ready = 1'b0;
    chk("R7 no words after error", 32'(ncap), 32'(base));
    rd(14'h004C, v); chk("R7 FIFO kept", v, 32'd8);
    rd(14'h0044, v); chk("R7 error bit", v, 32'h4);
    chk("R7 irq on error", {31'd0, irq}, 32'd1);

    // R11: push and send in the same cycle
    wr(14'h0040, 32'h0);
    wr(14'h0040, 32'h1);
    wr(14'h3000, 32'hCAFE0001);
    base = ncap;
    @(negedge clk);
    tgt_ready = 1'b1;
    bus_wr = 1'b1; bus_addr = 14'h3000; bus_wdata = 32'hCAFE0002;
    @(negedge clk);
    tgt_ready = 1'b0;
    bus_wr = 1'b0;
    idle(2);
    rd(14'h004C, v); chk("R11 occupancy unchanged", v, 32'd4);
    chk("R11 one word sent", 32'(ncap), 32'(base + 1));
    chk("R11 older word sent", cap[base], 32'hCAFE0001);

    finish_run();
  end
endmodule